// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Arbitration

This block is a synchronous memory with two fully independent ports, left and right, that may each read or write any word in any cycle. Each port has its own enable, write select, output enable, address and data lines. When both enabled ports present the same address in one cycle, a fixed-priority arbiter lets the left port through and raises a busy flag on the right port. The right port's write in that cycle is dropped.

A strap input picks the role of the device. As master, the internal arbiter produces the busy flags. As slave, the busy flags come from external inputs, normally the busy outputs of a master device. An asserted busy input blocks that port's write. Several devices can therefore be placed side by side to form a wider word, and all of them make the same arbitration decision. Word count (2^ADDR_W, typically 12 to 15 address bits) and word width (typically 8 or 9 bits) are parameters.

Top module: `dpr_collide_ram`

## Requirements
- R1: While rst_ni is low, and until the first read, both `*_rdata_en_o` are 0 and both `*_rdata_o` are all zero.
- R2: A word written on one port at a clock edge is returned by a read of that address on either port in any later cycle. Read data and its enable are registered and appear after the edge that ends the read cycle.
- R3: In a cycle with ce=1, we=0 and oe=1 the port shows `rdata_en_o`=1 and the addressed word after the edge. In any other cycle it shows `rdata_en_o`=0 with `rdata_o` all zero, which stands for a tri-stated bus.
- R4: A port with ce=0 writes nothing and returns no data, whatever we, oe, address and write data it is given.
- R5: In master mode (`master_i`=1), `rgt_busy_o` is 1 exactly when both ce inputs are 1 and the two addresses are equal, and `lft_busy_o` is always 0. The busy flags are combinational in the current cycle.
- R6: In master mode, when both ports write the same address in one cycle, the left data is stored and the right write is dropped.
- R7: Two reads of the same address in one cycle raise `rgt_busy_o`, and both ports still return the stored word.
- R8: When one port writes a word and the other port reads the same address in the same cycle, the read returns the contents from before the write.
- R9: In slave mode (`master_i`=0), each `*_busy_o` follows its `*_busy_i`. A port whose busy input is 1 does not write, but it still reads normally.
- R10: In slave mode with both busy inputs at 0, both ports writing the same address store the left data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| master_i | input | 1 | 1: internal arbiter drives busy; 0: busy taken from inputs |
| lft_ce_i | input | 1 | Left port enable |
| lft_we_i | input | 1 | Left port write (1) / read (0) |
| lft_oe_i | input | 1 | Left port output enable |
| lft_addr_i | input | ADDR_W | Left port address |
| lft_wdata_i | input | DATA_W | Left port write data |
| lft_busy_i | input | 1 | Left busy input (slave mode) |
| lft_rdata_o | output | DATA_W | Left read data, zero when not driven |
| lft_rdata_en_o | output | 1 | Left read data is being driven |
| lft_busy_o | output | 1 | Left busy flag |
| rgt_ce_i | input | 1 | Right port enable |
| rgt_we_i | input | 1 | Right port write (1) / read (0) |
| rgt_oe_i | input | 1 | Right port output enable |
| rgt_addr_i | input | ADDR_W | Right port address |
| rgt_wdata_i | input | DATA_W | Right port write data |
| rgt_busy_i | input | 1 | Right busy input (slave mode) |
| rgt_rdata_o | output | DATA_W | Right read data, zero when not driven |
| rgt_rdata_en_o | output | 1 | Right read data is being driven |
| rgt_busy_o | output | 1 | Right busy flag |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=9. The 16-word array makes it possible to sweep every left/right address pair with both ports writing, and to read both words back after each pair. Every collision and non-collision combination is therefore covered, along with every same-address read race. The 9-bit width checks that the extra data bit is stored and returned. The slave-mode sweep tries all four busy-input combinations at every address.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned P_LFT = 0;  // priority port on address match
  localparam int unsigned P_RGT = 1;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              master_i,
  input  logic [1:0]        ce_i,
  input  logic [ADDR_W-1:0] addr_l_i,
  input  logic [ADDR_W-1:0] addr_r_i,
  input  logic [1:0]        busy_ext_i,
  output logic [1:0]        busy_o
);
  import dpr_pkg::*;
  logic hit;
  assign hit = ce_i[P_LFT] & ce_i[P_RGT] & (addr_l_i == addr_r_i);

  always_comb begin
    if (master_i) begin
      busy_o[P_LFT] = 1'b0;
      busy_o[P_RGT] = hit;
    end else begin
      busy_o = busy_ext_i;
    end
  end
endmodule

// File: rtl/dpr_mem.sv
module dpr_mem #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic                   clk_i,
  input  logic [1:0]             we_i,
  input  logic [1:0][ADDR_W-1:0] addr_i,
  input  logic [1:0][DATA_W-1:0] wdata_i,
  output logic [1:0][DATA_W-1:0] rdata_o
);
  import dpr_pkg::*;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // right first so the left write prevails on a shared address
  always_ff @(posedge clk_i) begin
    if (we_i[P_RGT]) mem_q[addr_i[P_RGT]] <= wdata_i[P_RGT];
    if (we_i[P_LFT]) mem_q[addr_i[P_LFT]] <= wdata_i[P_LFT];
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rd
    assign rdata_o[g] = mem_q[addr_i[g]];
  end
endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              we_i,
  input  logic              oe_i,
  input  logic              blk_i,
  input  logic [DATA_W-1:0] mem_rd_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_en_o
);
  logic              rd_go;
  logic              en_q;
  logic [DATA_W-1:0] data_q;

  assign rd_go   = ce_i & ~we_i;
  assign wr_en_o = ce_i & we_i & ~blk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      data_q <= '0;
    end else begin
      en_q <= rd_go & oe_i;
      if (rd_go) data_q <= mem_rd_i;
    end
  end

  assign rdata_en_o = en_q;
  assign rdata_o    = en_q ? data_q : '0;
endmodule

// File: rtl/dpr_collide_ram.sv
module dpr_collide_ram #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              lft_ce_i,
  input  logic              lft_we_i,
  input  logic              lft_oe_i,
  input  logic [ADDR_W-1:0] lft_addr_i,
  input  logic [DATA_W-1:0] lft_wdata_i,
  input  logic              lft_busy_i,
  output logic [DATA_W-1:0] lft_rdata_o,
  output logic              lft_rdata_en_o,
  output logic              lft_busy_o,
  input  logic              rgt_ce_i,
  input  logic              rgt_we_i,
  input  logic              rgt_oe_i,
  input  logic [ADDR_W-1:0] rgt_addr_i,
  input  logic [DATA_W-1:0] rgt_wdata_i,
  input  logic              rgt_busy_i,
  output logic [DATA_W-1:0] rgt_rdata_o,
  output logic              rgt_rdata_en_o,
  output logic              rgt_busy_o
);
  import dpr_pkg::*;

  logic [1:0]             ce, we, oe, busy, wr_en, rd_en;
  logic [1:0][ADDR_W-1:0] addr;
  logic [1:0][DATA_W-1:0] wdata, mem_rd, rdata;

  assign ce    = {rgt_ce_i, lft_ce_i};
  assign we    = {rgt_we_i, lft_we_i};
  assign oe    = {rgt_oe_i, lft_oe_i};
  assign addr  = {rgt_addr_i, lft_addr_i};
  assign wdata = {rgt_wdata_i, lft_wdata_i};

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .master_i  (master_i),
    .ce_i      (ce),
    .addr_l_i  (lft_addr_i),
    .addr_r_i  (rgt_addr_i),
    .busy_ext_i({rgt_busy_i, lft_busy_i}),
    .busy_o    (busy)
  );

  dpr_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (wr_en),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(mem_rd)
  );

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    dpr_port #(.DATA_W(DATA_W)) u_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ce_i      (ce[g]),
      .we_i      (we[g]),
      .oe_i      (oe[g]),
      .blk_i     (busy[g]),
      .mem_rd_i  (mem_rd[g]),
      .wr_en_o   (wr_en[g]),
      .rdata_o   (rdata[g]),
      .rdata_en_o(rd_en[g])
    );
  end

  assign lft_rdata_o    = rdata[P_LFT];
  assign rgt_rdata_o    = rdata[P_RGT];
  assign lft_rdata_en_o = rd_en[P_LFT];
  assign rgt_rdata_en_o = rd_en[P_RGT];
  assign lft_busy_o     = busy[P_LFT];
  assign rgt_busy_o     = busy[P_RGT];
endmodule

// File: rtl/dpr_collide_ram_chk.sv
module dpr_collide_ram_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_i,
  input logic              lft_ce_i,
  input logic              lft_we_i,
  input logic              lft_oe_i,
  input logic [ADDR_W-1:0] lft_addr_i,
  input logic [DATA_W-1:0] lft_wdata_i,
  input logic              lft_busy_i,
  input logic [DATA_W-1:0] lft_rdata_o,
  input logic              lft_rdata_en_o,
  input logic              lft_busy_o,
  input logic              rgt_ce_i,
  input logic              rgt_we_i,
  input logic              rgt_oe_i,
  input logic [ADDR_W-1:0] rgt_addr_i,
  input logic [DATA_W-1:0] rgt_wdata_i,
  input logic              rgt_busy_i,
  input logic [DATA_W-1:0] rgt_rdata_o,
  input logic              rgt_rdata_en_o,
  input logic              rgt_busy_o
);
  AST_LFT_NEVER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |-> !lft_busy_o); // R5
  AST_RGT_BUSY_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && lft_ce_i && rgt_ce_i && lft_addr_i == rgt_addr_i) |-> rgt_busy_o); // R5
  AST_RGT_IDLE_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !rgt_ce_i) |-> !rgt_busy_o); // R5
  AST_SLAVE_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (lft_busy_o == lft_busy_i && rgt_busy_o == rgt_busy_i)); // R9
  AST_LFT_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lft_ce_i && !lft_we_i && lft_oe_i) |=> lft_rdata_en_o); // R3
  AST_LFT_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lft_ce_i |=> (!lft_rdata_en_o && lft_rdata_o == '0)); // R4
  AST_RGT_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rgt_ce_i |=> (!rgt_rdata_en_o && rgt_rdata_o == '0)); // R4
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rgt_ce_i && rgt_we_i) |=> !rgt_rdata_en_o); // R3
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!lft_rdata_en_o && !rgt_rdata_en_o)); // R1
  logic unused_ok;
  assign unused_ok = ^{lft_wdata_i, rgt_wdata_i, rgt_oe_i};
endmodule

bind dpr_collide_ram dpr_collide_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dpr_collide_ram_test.sv
module dpr_collide_ram_test;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 9;
  localparam int unsigned N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master = 1'b1;
  logic l_ce = 0, l_we = 0, l_oe = 0, l_bi = 0;
  logic r_ce = 0, r_we = 0, r_oe = 0, r_bi = 0;
  logic [AW-1:0] l_a = '0, r_a = '0;
  logic [DW-1:0] l_d = '0, r_d = '0;
  logic [DW-1:0] l_q, r_q;
  logic l_en, r_en, l_bo, r_bo;
  logic cap_lb, cap_rb;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [DW-1:0] model [N];

  always #10 clk = ~clk;

  dpr_collide_ram #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master),
    .lft_ce_i(l_ce), .lft_we_i(l_we), .lft_oe_i(l_oe), .lft_addr_i(l_a),
    .lft_wdata_i(l_d), .lft_busy_i(l_bi), .lft_rdata_o(l_q),
    .lft_rdata_en_o(l_en), .lft_busy_o(l_bo),
    .rgt_ce_i(r_ce), .rgt_we_i(r_we), .rgt_oe_i(r_oe), .rgt_addr_i(r_a),
    .rgt_wdata_i(r_d), .rgt_busy_i(r_bi), .rgt_rdata_o(r_q),
    .rgt_rdata_en_o(r_en), .rgt_busy_o(r_bo)
  );

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 37 + k * 101 + 5) % (1 << DW));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inputs set at negedge, busy captured before the edge, outputs seen at next negedge
  task automatic step(input logic lce, lwe, loe, input int la, input int ld,
                      input logic rce, rwe, roe, input int ra, input int rd);
    l_ce = lce; l_we = lwe; l_oe = loe; l_a = AW'(la); l_d = DW'(ld);
    r_ce = rce; r_we = rwe; r_oe = roe; r_a = AW'(ra); r_d = DW'(rd);
    #2;
    cap_lb = l_bo; cap_rb = r_bo;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 lft en", int'(l_en), 0);
    check("R1 rgt en", int'(r_en), 0);
    check("R1 lft data", int'(l_q), 0);
    check("R1 rgt data", int'(r_q), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(l_en | r_en), 0);

    // fill from left, right idle
    for (int a = 0; a < N; a++) begin
      step(1, 1, 0, a, pat(a, 0), 0, 0, 0, 0, 0);
      model[a] = pat(a, 0);
      check("R5 idle right no busy", int'(cap_rb), 0);
    end
    // read all from right, left reads with oe low
    for (int a = 0; a < N; a++) begin
      step(1, 0, 0, (a + 3) % N, 0, 1, 0, 1, a, 0);
      check("R2 rgt read en", int'(r_en), 1);
      check("R2 rgt read data", int'(r_q), int'(model[a]));
      check("R3 lft oe low en", int'(l_en), 0);
      check("R3 lft oe low data", int'(l_q), 0);
    end
    // R4: disabled port attempts write, then read with oe but no ce
    step(0, 1, 1, 5, 9'h1aa, 0, 1, 1, 6, 9'h155);
    check("R4 lft off en", int'(l_en), 0);
    check("R4 rgt off en", int'(r_en), 0);
    step(1, 0, 1, 5, 0, 1, 0, 1, 6, 0);
    check("R4 addr5 unchanged", int'(l_q), int'(model[5]));
    check("R4 addr6 unchanged", int'(r_q), int'(model[6]));
    step(0, 0, 1, 5, 0, 0, 0, 1, 6, 0);
    check("R4 lft no read", int'(l_en), 0);
    check("R3 rgt not driven", int'(r_q), 0);

    // R5/R6/R7: every pair with both writing, then cross read
    for (int la = 0; la < N; la++) begin
      for (int ra = 0; ra < N; ra++) begin
        int lv, rv;
        lv = int'(pat(la, ra + 1));
        rv = int'(pat(ra, la + 7));
        step(1, 1, 0, la, lv, 1, 1, 0, ra, rv);
        check("R5 rgt busy on write pair", int'(cap_rb), (la == ra) ? 1 : 0);
        check("R5 lft never busy", int'(cap_lb), 0);
        if (la != ra) model[ra] = DW'(rv);
        model[la] = DW'(lv);
        step(1, 0, 1, ra, 0, 1, 0, 1, la, 0);
        check("R7 rgt busy on read pair", int'(cap_rb), (la == ra) ? 1 : 0);
        check("R6 lft sees right addr", int'(l_q), int'(model[ra]));
        check("R6 rgt sees left addr", int'(r_q), int'(model[la]));
        check("R7 both drive", int'(l_en & r_en), 1);
      end
    end

    // R8: write on left, read same address on right in same cycle
    for (int a = 0; a < N; a++) begin
      logic [DW-1:0] old;
      old = model[a];
      step(1, 1, 0, a, ~int'(old), 1, 0, 1, a, 0);
      model[a] = ~old;
      check("R8 old contents", int'(r_q), int'(old));
      step(0, 0, 0, 0, 0, 1, 0, 1, a, 0);
      check("R8 new contents later", int'(r_q), int'(model[a]));
    end

    // R9: slave mode, all busy input combinations
    master = 1'b0;
    for (int b = 0; b < 4; b++) begin
      for (int a = 0; a < N; a++) begin
        int ra, lv, rv;
        ra = N - 1 - a;
        lv = int'(pat(a, b + 40));
        rv = int'(pat(ra, b + 60));
        l_bi = b[0]; r_bi = b[1];
        step(1, 1, 0, a, lv, 1, 1, 0, ra, rv);
        check("R9 lft busy follows", int'(cap_lb), b & 1);
        check("R9 rgt busy follows", int'(cap_rb), (b >> 1) & 1);
        if (!b[0]) model[a] = DW'(lv);
        if (!b[1]) model[ra] = DW'(rv);
        step(1, 0, 1, a, 0, 1, 0, 1, ra, 0);
        check("R9 lft write gated", int'(l_q), int'(model[a]));
        check("R9 rgt write gated", int'(r_q), int'(model[ra]));
        check("R9 reads under busy", int'(l_en & r_en), 1);
      end
    end
    // R10: slave, no busy, same address written by both
    l_bi = 0; r_bi = 0;
    for (int a = 0; a < N; a++) begin
      step(1, 1, 0, a, pat(a, 90), 1, 1, 0, a, pat(a, 91));
      model[a] = pat(a, 90);
      step(1, 0, 1, a, 0, 0, 0, 0, 0, 0);
      check("R10 slave left prevails", int'(l_q), int'(model[a]));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule